// File: doc/BRIEF.md
# Dual-Channel Power-Good Window Monitor

This block decides, for each regulator channel, whether the channel's power-good pad should be pulled low. Each channel presents a digitised feedback sample on a valid/ready stream. The sample is an unsigned code in units of 0.1% of the regulation reference, so 1000 means exactly on target. Two hysteretic comparators per channel track an overvoltage fault and an undervoltage fault. Each comparator has its own set level and its own, separate release level.

A channel's power-good is released only when four conditions hold: the system enable, the channel enable, a completed soft-start and an absence of both faults. Dropping either enable forces the pull-down in the same cycle, without waiting for a clock edge. The overvoltage state of each channel is also exported so that the regulation logic can act on it. The two channels share no state.

The feedback stream never applies back-pressure. `fb_ready` is held high out of reset, and a sample is taken on every edge where its `fb_valid` bit is high. When `fb_valid` is low, the code lines of that channel are ignored.

Top module: `pg_window_monitor`

## Requirements
- R1: After reset, every `pg_pull_low` bit is 1, every `ov_flag` bit is 0, and every `fb_ready` bit is 1.
- R2: If `sys_en` is 0, every `pg_pull_low` bit is 1. If `ch_en[i]` is 0, `pg_pull_low[i]` is 1. Both hold in the same cycle as the enable change, with no clock edge needed.
- R3: `pg_pull_low[i]` stays 1 while `ss_done[i]` is 0. It goes to 0 at the first rising edge at which `sys_en`, `ch_en[i]` and `ss_done[i]` are all 1 and channel i has no fault.
- R4: A sample on channel i with a code strictly above OV_SET (default 1150) sets `ov_flag[i]` at that edge. A code equal to 1150 does not set it.
- R5: Once set, `ov_flag[i]` clears only on a sample strictly below OV_CLR (default 1100). Samples from 1100 to 1150 leave it set. While it is set, `pg_pull_low[i]` is 1 from the following edge onward.
- R6: A sample strictly below UV_SET (default 850) sets the undervoltage fault at that edge. `pg_pull_low[i]` is then 1 from the following edge onward. A code equal to 850 does not set the fault.
- R7: The undervoltage fault clears only on a sample strictly above UV_CLR (default 900). Samples from 850 to 900 keep `pg_pull_low[i]` at 1.
- R8: Channel i's feedback, enable and soft-start inputs have no effect on the outputs of any other channel.
- R9: While `fb_valid[i]` is 0, the value on channel i's code lines has no effect on `ov_flag[i]` or `pg_pull_low[i]`.
- R10: `fb_ready` is 1 in every cycle after reset, so no sample is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en | input | 1 | System-wide enable |
| ch_en | input | NCH | Per-channel enable |
| ss_done | input | NCH | Per-channel soft-start completed |
| fb_valid | input | NCH | Feedback sample valid, one bit per channel |
| fb_code | input | NCH*CODE_W | Feedback codes; channel i occupies bits [i*CODE_W +: CODE_W] |
| fb_ready | output | NCH | Feedback sample accepted (always 1) |
| pg_pull_low | output | NCH | 1 = pull channel power-good pad low |
| ov_flag | output | NCH | Channel overvoltage fault state |

## Verification
A sample accepted at edge k shows up on `ov_flag` just after edge k. It reaches `pg_pull_low` just after edge k+1, because the release decision is a second register. An enable that is switched on reaches `pg_pull_low` one edge later. An enable that is switched off reaches it at once, so the bench samples 1 ns after the change with no edge in between. The bench drives inputs and reads outputs 2 ns after each rising edge and counts the edges between a stimulus and its check to match these latencies. The threshold checks sit on the exact set and release codes and one code beyond each.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Direction in which a comparator trips
  typedef enum logic {
    TRIP_ABOVE = 1'b0,
    TRIP_BELOW = 1'b1
  } trip_dir_e;

  // Per-channel fault pair
  typedef struct packed {
    logic ov;
    logic uv;
  } fault_t;

endpackage

// File: rtl/pg_hyst_cmp.sv
module pg_hyst_cmp
  import pg_pkg::*;
#(
  parameter int unsigned CODE_W  = 11,
  parameter int unsigned SET_LVL = 1150,
  parameter int unsigned CLR_LVL = 1100,
  parameter trip_dir_e   DIR     = TRIP_ABOVE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [CODE_W-1:0] code,
  output logic              fault
);

  localparam logic [CODE_W-1:0] SET_C = SET_LVL[CODE_W-1:0];
  localparam logic [CODE_W-1:0] CLR_C = CLR_LVL[CODE_W-1:0];

  logic trip;
  logic release_ok;
  logic fault_q;
  logic fault_d;

  generate
    if (DIR == TRIP_ABOVE) begin : g_above
      assign trip       = (code > SET_C);
      assign release_ok = (code < CLR_C);
    end else begin : g_below
      assign trip       = (code < SET_C);
      assign release_ok = (code > CLR_C);
    end
  endgenerate

  always_comb begin
    fault_d = fault_q;
    if (sample) begin
      if (!fault_q && trip)
        fault_d = 1'b1;
      else if (fault_q && release_ok)
        fault_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault = fault_q;

endmodule

// File: rtl/pg_channel.sv
module pg_channel
  import pg_pkg::*;
#(
  parameter int unsigned CODE_W = 11,
  parameter int unsigned OV_SET = 1150,
  parameter int unsigned OV_CLR = 1100,
  parameter int unsigned UV_SET = 850,
  parameter int unsigned UV_CLR = 900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_en,
  input  logic              ch_en,
  input  logic              ss_done,
  input  logic              fb_valid,
  input  logic [CODE_W-1:0] fb_code,
  output logic              pull_low,
  output logic              ov
);

  fault_t flt;
  logic   enabled;
  logic   good_q;

  pg_hyst_cmp #(
    .CODE_W (CODE_W),
    .SET_LVL(OV_SET),
    .CLR_LVL(OV_CLR),
    .DIR    (TRIP_ABOVE)
  ) u_ov (
    .clk   (clk),
    .rst_n (rst_n),
    .sample(fb_valid),
    .code  (fb_code),
    .fault (flt.ov)
  );

  pg_hyst_cmp #(
    .CODE_W (CODE_W),
    .SET_LVL(UV_SET),
    .CLR_LVL(UV_CLR),
    .DIR    (TRIP_BELOW)
  ) u_uv (
    .clk   (clk),
    .rst_n (rst_n),
    .sample(fb_valid),
    .code  (fb_code),
    .fault (flt.uv)
  );

  assign enabled = sys_en & ch_en;

  // Registered release decision keeps the pad request free of glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= enabled & ss_done & ~flt.ov & ~flt.uv;
  end

  // Enable removal bypasses the register so the pad drops at once
  assign pull_low = ~good_q | ~enabled;
  assign ov       = flt.ov;

endmodule

// File: rtl/pg_window_monitor.sv
module pg_window_monitor #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned CODE_W = 11,
  parameter int unsigned OV_SET = 1150,
  parameter int unsigned OV_CLR = 1100,
  parameter int unsigned UV_SET = 850,
  parameter int unsigned UV_CLR = 900
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sys_en,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH-1:0]        ss_done,
  input  logic [NCH-1:0]        fb_valid,
  input  logic [NCH*CODE_W-1:0] fb_code,
  output logic [NCH-1:0]        fb_ready,
  output logic [NCH-1:0]        pg_pull_low,
  output logic [NCH-1:0]        ov_flag
);

  // Every sample is accepted; there is no back-pressure
  assign fb_ready = '1;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      pg_channel #(
        .CODE_W(CODE_W),
        .OV_SET(OV_SET),
        .OV_CLR(OV_CLR),
        .UV_SET(UV_SET),
        .UV_CLR(UV_CLR)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_en  (sys_en),
        .ch_en   (ch_en[i]),
        .ss_done (ss_done[i]),
        .fb_valid(fb_valid[i]),
        .fb_code (fb_code[i*CODE_W +: CODE_W]),
        .pull_low(pg_pull_low[i]),
        .ov      (ov_flag[i])
      );
    end
  endgenerate

endmodule

// File: rtl/pg_window_monitor_chk.sv
module pg_window_monitor_chk #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned CODE_W = 11,
  parameter int unsigned OV_SET = 1150,
  parameter int unsigned OV_CLR = 1100,
  parameter int unsigned UV_SET = 850,
  parameter int unsigned UV_CLR = 900
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sys_en,
  input logic [NCH-1:0]        ch_en,
  input logic [NCH-1:0]        ss_done,
  input logic [NCH-1:0]        fb_valid,
  input logic [NCH*CODE_W-1:0] fb_code,
  input logic [NCH-1:0]        fb_ready,
  input logic [NCH-1:0]        pg_pull_low,
  input logic [NCH-1:0]        ov_flag
);

  localparam logic [CODE_W-1:0] OVS = OV_SET[CODE_W-1:0];
  localparam logic [CODE_W-1:0] OVC = OV_CLR[CODE_W-1:0];
  localparam logic [CODE_W-1:0] UVS = UV_SET[CODE_W-1:0];
  localparam logic [CODE_W-1:0] UVC = UV_CLR[CODE_W-1:0];

  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    &fb_ready);

  assert_sys_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_en |-> &pg_pull_low);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      wire [CODE_W-1:0] c = fb_code[i*CODE_W +: CODE_W];

      assert_ch_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[i] |-> pg_pull_low[i]);

      assert_needs_softstart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_pull_low[i] |-> $past(ss_done[i]));

      assert_ov_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_valid[i] && (c > OVS) |=> ov_flag[i]);

      assert_ov_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag[i] && fb_valid[i] && (c >= OVC) |=> ov_flag[i]);

      assert_ov_pulls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag[i] |=> pg_pull_low[i]);

      assert_uv_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_valid[i] && (c < UVS) |-> ##2 pg_pull_low[i]);

      assert_uv_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fb_valid[i] && (c < UVS) ##1 (!fb_valid[i] || (c <= UVC)) |-> ##1 pg_pull_low[i]);

      assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_valid[i] |=> $stable(ov_flag[i]));
    end
  endgenerate

endmodule

bind pg_window_monitor pg_window_monitor_chk #(
  .NCH   (NCH),
  .CODE_W(CODE_W),
  .OV_SET(OV_SET),
  .OV_CLR(OV_CLR),
  .UV_SET(UV_SET),
  .UV_CLR(UV_CLR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sys_en     (sys_en),
  .ch_en      (ch_en),
  .ss_done    (ss_done),
  .fb_valid   (fb_valid),
  .fb_code    (fb_code),
  .fb_ready   (fb_ready),
  .pg_pull_low(pg_pull_low),
  .ov_flag    (ov_flag)
);

// File: tb/test_pg_window_monitor.sv
module test_pg_window_monitor;

  localparam int PERIOD = 10;
  localparam int NCH    = 2;
  localparam int W      = 11;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           sys_en;
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] ss_done;
  logic [NCH-1:0] fb_valid;
  logic [NCH*W-1:0] fb_code;
  logic [NCH-1:0] fb_ready;
  logic [NCH-1:0] pg_pull_low;
  logic [NCH-1:0] ov_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  pg_window_monitor i_pg_window_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_en     (sys_en),
    .ch_en      (ch_en),
    .ss_done    (ss_done),
    .fb_valid   (fb_valid),
    .fb_code    (fb_code),
    .fb_ready   (fb_ready),
    .pg_pull_low(pg_pull_low),
    .ov_flag    (ov_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance n rising edges, then settle 2 ns past the last one
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // One sample on channel ch, accepted at the next edge
  task automatic send(input int ch, input int code);
    fb_code[ch*W +: W] = code[W-1:0];
    fb_valid[ch] = 1'b1;
    edges(1);
    fb_valid[ch] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pull_low", 32'(pg_pull_low), 32'h3);
    chk("R1 ov_flag", 32'(ov_flag), 32'h0);
    chk("R1 fb_ready", 32'(fb_ready), 32'h3);
  endtask

  task automatic t_enable_gating;
    sys_en = 1'b1;
    ch_en  = 2'b11;
    send(0, 1000);
    send(1, 1000);
    edges(2);
    chk("R3 waits for soft-start", 32'(pg_pull_low), 32'h3);
    ss_done = 2'b11;
    edges(1);
    chk("R3 released one edge after soft-start", 32'(pg_pull_low), 32'h0);
    ch_en[0] = 1'b0;
    #1;
    chk("R2 channel enable drop immediate", 32'(pg_pull_low[0]), 32'h1);
    chk("R8 other channel unaffected by enable", 32'(pg_pull_low[1]), 32'h0);
    edges(1);
    ch_en[0] = 1'b1;
    edges(1);
    chk("R3 re-release after enable", 32'(pg_pull_low), 32'h0);
    sys_en = 1'b0;
    #1;
    chk("R2 system enable drop immediate", 32'(pg_pull_low), 32'h3);
    edges(1);
    sys_en = 1'b1;
    edges(1);
    chk("R3 release after system enable", 32'(pg_pull_low), 32'h0);
  endtask

  task automatic t_overvoltage;
    send(0, 1150);
    chk("R4 no set at 1150", 32'(ov_flag[0]), 32'h0);
    send(0, 1151);
    chk("R4 set at 1151", 32'(ov_flag[0]), 32'h1);
    edges(1);
    chk("R5 ov pulls channel 0 low", 32'(pg_pull_low[0]), 32'h1);
    chk("R8 channel 1 still good", 32'(pg_pull_low[1]), 32'h0);
    chk("R8 channel 1 ov clear", 32'(ov_flag[1]), 32'h0);
    send(0, 1100);
    chk("R5 hold at 1100", 32'(ov_flag[0]), 32'h1);
    send(0, 1099);
    chk("R5 clear at 1099", 32'(ov_flag[0]), 32'h0);
    edges(1);
    chk("R5 pad released after clear", 32'(pg_pull_low[0]), 32'h0);
  endtask

  task automatic t_undervoltage;
    send(1, 850);
    edges(1);
    chk("R6 no fault at 850", 32'(pg_pull_low[1]), 32'h0);
    send(1, 849);
    edges(1);
    chk("R6 fault at 849", 32'(pg_pull_low[1]), 32'h1);
    chk("R8 channel 0 untouched by uv", 32'(pg_pull_low[0]), 32'h0);
    send(1, 900);
    edges(1);
    chk("R7 hold at 900", 32'(pg_pull_low[1]), 32'h1);
    send(1, 901);
    edges(1);
    chk("R7 clear at 901", 32'(pg_pull_low[1]), 32'h0);
  endtask

  task automatic t_valid_gate;
    fb_code[0 +: W] = 11'd2000;
    fb_valid[0] = 1'b0;
    edges(3);
    chk("R9 ov ignores idle code", 32'(ov_flag[0]), 32'h0);
    chk("R9 pad ignores idle code", 32'(pg_pull_low[0]), 32'h0);
    chk("R10 ready stays high", 32'(fb_ready), 32'h3);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    sys_en   = 1'b0;
    ch_en    = '0;
    ss_done  = '0;
    fb_valid = '0;
    fb_code  = '0;
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_enable_gating();
    t_overvoltage();
    t_undervoltage();
    t_valid_gate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule